// File: doc/BRIEF.md
# DMA-Gated Selection Command Launcher

This block sits in the front end of a SCSI bus controller, between command decode and the sequencer that starts a selection. Some selection commands fetch their command bytes by DMA. Such a command cannot start while the DMA channel is disabled. The launcher passes a selection command straight through when the DMA-enable level allows it. Otherwise it holds the command's kind in a single pending slot and replays it on its own at the next rising edge of DMA-enable.

A falling DMA-enable edge only drops the enabled flag, so a held command survives it. A controller reset empties the slot. Platforms with no enable source set the `STRAP_EN` parameter, which makes the flag come out of reset already set. Command strobes are single-cycle pulses with no back-pressure: the launcher always accepts them. The start strobe is likewise a one-cycle pulse that the sequencer must take in the cycle it appears. The block does not execute commands or fetch bytes.

Top module: `dma_gated_cmd_defer`

## Requirements
- R1: After `rst_n` is released, `start_valid` is low, no command is held, and the enabled flag equals `STRAP_EN`.
- R2: Kind codes are 1 = select with attention, 2 = select without attention and 3 = select with attention and stop. A strobe with kind 0 produces no start and leaves a held command unchanged.
- R3: A gated command that arrives while the block is enabled raises `start_valid` in the same cycle, with `start_kind` equal to `cmd_kind`, and leaves the pending slot untouched.
- R4: A gated command that arrives while the block is disabled produces no start, and its kind is held.
- R5: In the cycle `dma_en` is first seen high after being low, a held command is started once with its stored kind and the slot is emptied. A later rising edge starts nothing more.
- R6: A falling edge of `dma_en` clears the enabled flag and keeps any held command. A command in the cycle of the fall is held.
- R7: A gated command that arrives while another is held replaces it.
- R8: While `ctl_reset` is high, `start_valid` stays low and the pending slot is emptied. The enabled flag still follows `dma_en`.
- R9: With `STRAP_EN` = 1, a gated command after reset starts at once, even though `dma_en` never rose.
- R10: A gated command in the same cycle as a rising edge starts itself, and any older held command is dropped.
- R11: A rising edge with nothing held produces no start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_reset | input | 1 | Synchronous controller reset, empties the pending slot |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_kind | input | KIND_W | Kind of the strobed command, 0 = not gated |
| dma_en | input | 1 | DMA-enable level |
| start_valid | output | 1 | One-cycle start strobe |
| start_kind | output | KIND_W | Kind of the started command |

## Verification
The rising edge of DMA-enable, which replays a held command, can coincide with a fresh command strobe, and only one start can leave per cycle. The bench holds one kind, then drives a different kind in the cycle `dma_en` goes high. It expects the fresh kind on the start strobe in that cycle. It then lowers and raises `dma_en` again and expects no start, which proves the older command was dropped. The same coincidence with the falling edge is provoked as well: the strobe must be held and then start at the next rise.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  localparam int KIND_W = 2;
  typedef enum logic [KIND_W-1:0] {
    CK_NONE         = 2'd0,
    CK_SEL_ATN      = 2'd1,
    CK_SEL_PLAIN    = 2'd2,
    CK_SEL_ATN_STOP = 2'd3
  } cmd_kind_e;

  function automatic logic is_gated(input logic [KIND_W-1:0] k);
    return (k == CK_SEL_ATN) || (k == CK_SEL_PLAIN) || (k == CK_SEL_ATN_STOP);
  endfunction
endpackage

// File: rtl/dgc_edge_sense.sv
module dgc_edge_sense #(
  parameter bit STRAP_EN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall,
  output logic prev_q,
  output logic en_q,
  output logic en_live
);
  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    if (rise)      en_live = 1'b1;
    else if (fall) en_live = 1'b0;
    else           en_live = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      en_q   <= STRAP_EN;
    end else begin
      prev_q <= lvl;
      en_q   <= en_live;
    end
  end
endmodule

// File: rtl/dgc_pend_slot.sv
module dgc_pend_slot #(
  parameter int KIND_W = dgc_pkg::KIND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [KIND_W-1:0] kind_in,
  output logic              pend_v,
  output logic [KIND_W-1:0] pend_kind
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_kind <= '0;
    end else if (load) begin
      pend_v    <= 1'b1;
      pend_kind <= kind_in;
    end else if (clear) begin
      pend_v    <= 1'b0;
      pend_kind <= '0;
    end
  end
endmodule

// File: rtl/dgc_launch.sv
module dgc_launch #(
  parameter int KIND_W = dgc_pkg::KIND_W
) (
  input  logic              ctl_reset,
  input  logic              cmd_valid,
  input  logic [KIND_W-1:0] cmd_kind,
  input  logic              rise,
  input  logic              en_live,
  input  logic              pend_v,
  input  logic [KIND_W-1:0] pend_kind,
  output logic              pend_load,
  output logic              pend_clear,
  output logic              start_valid,
  output logic [KIND_W-1:0] start_kind
);
  logic gated;
  assign gated = cmd_valid & dgc_pkg::is_gated(cmd_kind);

  always_comb begin
    pend_load   = 1'b0;
    pend_clear  = 1'b0;
    start_valid = 1'b0;
    start_kind  = '0;
    if (ctl_reset) begin
      pend_clear = 1'b1;
    end else if (gated && en_live) begin
      start_valid = 1'b1;
      start_kind  = cmd_kind;
      pend_clear  = rise;
    end else if (gated) begin
      pend_load = 1'b1;
    end else if (rise && pend_v) begin
      start_valid = 1'b1;
      start_kind  = pend_kind;
      pend_clear  = 1'b1;
    end
  end
endmodule

// File: rtl/dma_gated_cmd_defer.sv
module dma_gated_cmd_defer #(
  parameter bit STRAP_EN = 1'b0,
  parameter int KIND_W   = dgc_pkg::KIND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_reset,
  input  logic              cmd_valid,
  input  logic [KIND_W-1:0] cmd_kind,
  input  logic              dma_en,
  output logic              start_valid,
  output logic [KIND_W-1:0] start_kind
);
  logic              rise, fall, dma_prev, en_q, en_live;
  logic              pend_v, pend_load, pend_clear;
  logic [KIND_W-1:0] pend_kind;

  dgc_edge_sense #(.STRAP_EN(STRAP_EN)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(dma_en),
    .rise(rise), .fall(fall), .prev_q(dma_prev),
    .en_q(en_q), .en_live(en_live)
  );

  dgc_pend_slot #(.KIND_W(KIND_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(pend_load), .clear(pend_clear),
    .kind_in(cmd_kind), .pend_v(pend_v), .pend_kind(pend_kind)
  );

  dgc_launch #(.KIND_W(KIND_W)) u_launch (
    .ctl_reset(ctl_reset), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .rise(rise), .en_live(en_live), .pend_v(pend_v), .pend_kind(pend_kind),
    .pend_load(pend_load), .pend_clear(pend_clear),
    .start_valid(start_valid), .start_kind(start_kind)
  );
endmodule

// File: rtl/dgc_checker.sv
module dgc_checker #(
  parameter int KIND_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_reset,
  input logic              cmd_valid,
  input logic [KIND_W-1:0] cmd_kind,
  input logic              dma_en,
  input logic              start_valid,
  input logic [KIND_W-1:0] start_kind,
  input logic              en_q,
  input logic              dma_prev,
  input logic              pend_v,
  input logic [KIND_W-1:0] pend_kind
);
  logic gated;
  assign gated = cmd_valid && (cmd_kind != '0);

  assert_kind_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> (start_kind != '0));

  assert_direct_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_reset && gated && en_q && dma_en) |-> (start_valid && start_kind == cmd_kind));

  assert_defer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_reset && gated && !dma_en && !en_q) |=> (pend_v && pend_kind == $past(cmd_kind)));

  assert_replay_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_reset && !cmd_valid && pend_v && dma_en && !dma_prev)
      |-> (start_valid && start_kind == pend_kind));

  assert_replay_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_reset && !cmd_valid && pend_v && dma_en && !dma_prev) |=> !pend_v);

  assert_fall_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_reset && !cmd_valid && pend_v && !dma_en) |=> (pend_v && $stable(pend_kind)));

  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |-> !start_valid);

  assert_reset_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> !pend_v);

  assert_held_only_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> !en_q);
endmodule

bind dma_gated_cmd_defer dgc_checker #(.KIND_W(KIND_W)) u_dgc_checker (
  .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .cmd_valid(cmd_valid),
  .cmd_kind(cmd_kind), .dma_en(dma_en), .start_valid(start_valid),
  .start_kind(start_kind), .en_q(en_q), .dma_prev(dma_prev),
  .pend_v(pend_v), .pend_kind(pend_kind)
);

// File: tb/test_dma_gated_cmd_defer.sv
module test_dma_gated_cmd_defer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_reset = 1'b0, cmd_valid = 1'b0, dma_en = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic start_valid;
  logic [1:0] start_kind;
  logic s_cmd_valid = 1'b0, s_dma_en = 1'b0;
  logic [1:0] s_cmd_kind = 2'd0;
  logic s_start_valid;
  logic [1:0] s_start_kind;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_gated_cmd_defer i_dma_gated_cmd_defer (
    .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .dma_en(dma_en),
    .start_valid(start_valid), .start_kind(start_kind)
  );

  dma_gated_cmd_defer #(.STRAP_EN(1'b1)) i_dma_gated_cmd_defer_strap (
    .clk(clk), .rst_n(rst_n), .ctl_reset(1'b0), .cmd_valid(s_cmd_valid),
    .cmd_kind(s_cmd_kind), .dma_en(s_dma_en),
    .start_valid(s_start_valid), .start_kind(s_start_kind)
  );

  // vector: {req[11:8], ctl_reset, cmd_valid, kind[1:0], dma_en, exp_sv, exp_kind[1:0]}
  localparam int NV = 35;
  localparam logic [11:0] VEC [NV] = '{
    {4'd4,  1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R4 idle, disabled
    {4'd4,  1'b0,1'b1,2'd1,1'b0, 1'b0,2'd0}, // R4 defer kind 1
    {4'd4,  1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R4 still held
    {4'd5,  1'b0,1'b0,2'd0,1'b1, 1'b1,2'd1}, // R5 rise replays kind 1
    {4'd5,  1'b0,1'b0,2'd0,1'b1, 1'b0,2'd0}, // R5 only once
    {4'd3,  1'b0,1'b1,2'd2,1'b1, 1'b1,2'd2}, // R3 direct launch
    {4'd2,  1'b0,1'b1,2'd0,1'b1, 1'b0,2'd0}, // R2 kind 0 ignored
    {4'd6,  1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R6 fall
    {4'd7,  1'b0,1'b1,2'd3,1'b0, 1'b0,2'd0}, // R7 defer kind 3
    {4'd7,  1'b0,1'b1,2'd2,1'b0, 1'b0,2'd0}, // R7 replace with kind 2
    {4'd2,  1'b0,1'b1,2'd0,1'b0, 1'b0,2'd0}, // R2 kind 0 leaves held kind
    {4'd7,  1'b0,1'b0,2'd0,1'b1, 1'b1,2'd2}, // R7 replacement replayed
    {4'd5,  1'b0,1'b0,2'd0,1'b1, 1'b0,2'd0}, // R5 no repeat
    {4'd11, 1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R11 fall
    {4'd11, 1'b0,1'b0,2'd0,1'b1, 1'b0,2'd0}, // R11 rise, nothing held
    {4'd4,  1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R4 fall
    {4'd4,  1'b0,1'b1,2'd1,1'b0, 1'b0,2'd0}, // R4 defer kind 1
    {4'd6,  1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R6 held while low
    {4'd5,  1'b0,1'b0,2'd0,1'b1, 1'b1,2'd1}, // R5 replay
    {4'd3,  1'b0,1'b0,2'd0,1'b1, 1'b0,2'd0}, // R3 idle enabled
    {4'd6,  1'b0,1'b1,2'd3,1'b0, 1'b0,2'd0}, // R6 command on fall is held
    {4'd6,  1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R6 held
    {4'd6,  1'b0,1'b0,2'd0,1'b1, 1'b1,2'd3}, // R6 replay after fall
    {4'd10, 1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R10 fall
    {4'd10, 1'b0,1'b1,2'd1,1'b0, 1'b0,2'd0}, // R10 hold kind 1
    {4'd10, 1'b0,1'b1,2'd2,1'b1, 1'b1,2'd2}, // R10 fresh wins on rise
    {4'd10, 1'b0,1'b0,2'd0,1'b1, 1'b0,2'd0}, // R10
    {4'd10, 1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R10 fall
    {4'd10, 1'b0,1'b0,2'd0,1'b1, 1'b0,2'd0}, // R10 old command dropped
    {4'd8,  1'b0,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R8 fall
    {4'd8,  1'b0,1'b1,2'd3,1'b0, 1'b0,2'd0}, // R8 hold kind 3
    {4'd8,  1'b1,1'b0,2'd0,1'b0, 1'b0,2'd0}, // R8 controller reset
    {4'd8,  1'b0,1'b0,2'd0,1'b1, 1'b0,2'd0}, // R8 slot was emptied
    {4'd8,  1'b1,1'b1,2'd1,1'b1, 1'b0,2'd0}, // R8 no start under reset
    {4'd8,  1'b0,1'b1,2'd2,1'b1, 1'b1,2'd2}  // R8 flag kept through reset
  };

  task automatic check(input string req, input logic sv, input logic [1:0] sk,
                       input logic esv, input logic [1:0] esk);
    n_cmp++;
    if (sv !== esv || (esv && sk !== esk)) begin
      n_bad++;
      $display("FAIL %s: start_valid=%0b kind=%0d, expected %0b kind=%0d",
               req, sv, sk, esv, esk);
    end
  endtask

  task automatic step(input logic r, input logic cv, input logic [1:0] k,
                      input logic d);
    @(negedge clk);
    ctl_reset = r; cmd_valid = cv; cmd_kind = k; dma_en = d;
    #5;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #5;
    check("R1", start_valid, start_kind, 1'b0, 2'd0);
    check("R1", s_start_valid, s_start_kind, 1'b0, 2'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5:4], VEC[i][3]);
      check($sformatf("R%0d vec%0d", VEC[i][11:8], i),
            start_valid, start_kind, VEC[i][2], VEC[i][1:0]);
    end

    // R1: asynchronous reset empties the slot and clears the flag
    step(1'b0, 1'b0, 2'd0, 1'b0);
    step(1'b0, 1'b1, 2'd3, 1'b0);
    @(negedge clk); rst_n = 1'b0; cmd_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1; #5;
    check("R1 after reset", start_valid, start_kind, 1'b0, 2'd0);
    step(1'b0, 1'b0, 2'd0, 1'b1);
    check("R1 slot empty", start_valid, start_kind, 1'b0, 2'd0);
    step(1'b0, 1'b0, 2'd0, 1'b0);
    step(1'b0, 1'b1, 2'd1, 1'b0);
    check("R1 flag low after reset", start_valid, start_kind, 1'b0, 2'd0);
    step(1'b0, 1'b0, 2'd0, 1'b0);

    // R9: strapped instance starts with no rising edge
    @(negedge clk); s_cmd_valid = 1'b1; s_cmd_kind = 2'd2; #5;
    check("R9 strap direct", s_start_valid, s_start_kind, 1'b1, 2'd2);
    @(negedge clk); s_cmd_valid = 1'b0; #5;
    check("R9 strap pulse", s_start_valid, s_start_kind, 1'b0, 2'd0);
    @(negedge clk); s_cmd_valid = 1'b1; s_cmd_kind = 2'd3; #5;
    check("R9 strap again", s_start_valid, s_start_kind, 1'b1, 2'd3);
    @(negedge clk); s_cmd_valid = 1'b0; s_dma_en = 1'b1; #5;
    @(negedge clk); s_dma_en = 1'b0; #5;
    @(negedge clk); s_cmd_valid = 1'b1; s_cmd_kind = 2'd1; #5;
    check("R9 strap cleared by fall", s_start_valid, s_start_kind, 1'b0, 2'd0);
    @(negedge clk); s_cmd_valid = 1'b0; s_dma_en = 1'b1; #5;
    check("R9 held then replayed", s_start_valid, s_start_kind, 1'b1, 2'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule